// File: doc/BRIEF.md
# Transceiver eye-monitor enable sequencer

This block is a small hardware program runner that prepares a serial receiver's on-die eye-measurement path, the bit-error counting checker, for a sweep. A single start pulse launches a fixed, conditional list of steps. The block carries them out over a memory-mapped master port that has an 11-bit address and 8-bit data. Most steps change one field of one register by reading it, merging the new field value and writing it back.

Some steps depend on the inputs latched at start: the production-variant flag, the background-calibration flag, a 3-bit count-length code and a 2-bit bandwidth code. Other steps depend on a mode register the block reads on the way. One step polls a status bit with a bounded number of reads. Another waits a fixed time derived from the clock frequency before it samples the tap-1 sign of the decision-feedback equalizer.

At the end the block pulses `done_o`. If polling gave up, `err_o` is also raised. The captured tap-1 sign is held on `tap1_o` until the next accepted start.

Top module: `eyemon_enable_seq`

## Requirements
- R1: A start pulse is accepted only while the block is idle. All four configuration inputs are latched at that moment. A start pulse, or an input change, during a run has no effect on the transfers of that run.
- R2: There is at most one access at a time: read and write are never high together. A request keeps its address, direction and write data unchanged while `bus_wait_i` is high. Read data is taken in the cycle where the read is high and `bus_wait_i` is low.
- R3: Every field update reads the register, replaces only the field bits and writes the result back. All other bits of the register are preserved.
- R4: When both the production and the calibration flags are latched as 1, the program starts in two steps. It first clears bit 0 of 0x542. It then reads 0x481 repeatedly until bit 2 reads 0. When either flag is 0, both steps are skipped.
- R5: If `POLL_MAX` consecutive reads of 0x481 all show bit 2 at 1, the block stops issuing accesses. It then raises `err_o` together with a `done_o` pulse in the cycle after the last read is accepted. `err_o` stays high until the next start is accepted.
- R6: The block reads 0x161. If bit 5 is 1 (manual adaptation), it sets bit 0 of 0x148. Otherwise that step is skipped.
- R7: If bit 6 of 0x161 read 0 (equalizer on), the block sets bit 2 of 0x169 and writes 0x07 into bits 5:0 of 0x149. It then waits at least `CLK_MHZ*WAIT_US` cycles before reading 0x17F, and drives bit 6 of that read on `tap1_o`. If bit 6 of 0x161 read 1, the block clears bit 2 of 0x169, skips the other three steps, and `tap1_o` stays 0.
- R8: The count code is split across two registers. Code bits 2:1 go to 0x169 bits 1:0, and code bit 0 goes to 0x168 bit 5.
- R9: The bandwidth code is split across two registers. Code bit 1 goes to 0x145 bit 7, and code bit 0 goes to 0x144 bit 7.
- R10: The program runs in this order:
  - 0x169 bit 6 := 1
  - 0x168 bit 0 := 1
  - the equalizer steps of R7
  - the R8 fields
  - 0x158 bit 5 := 1
  - 0x12D bit 4 := 0
  - the R9 fields
  - 0x144 bits 6:4 := 0
  - 0x140 bits 5:3 := 0
  - 0x13C bit 0 := 0, then 0x13C bit 0 := 1
  - 0x171 bits 4:1 := 0xB

  The R4 and R6 steps come before this list.
- R11: After a normal run, `done_o` is high for exactly one cycle: the second cycle after the final write is accepted. `tap1_o` and `err_o` hold their values until the next accepted start.
- R12: After reset, `done_o`, `err_o`, `tap1_o`, `bus_read_o` and `bus_write_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| prod_i | input | 1 | Production-variant flag |
| bgcal_i | input | 1 | Background calibration enabled |
| cnt_code_i | input | 3 | Error-count length code (0 to 6) |
| bw_code_i | input | 2 | Bandwidth code chosen for the data rate |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Polling timeout flag |
| tap1_o | output | 1 | Captured equalizer tap-1 sign |
| bus_addr_o | output | 11 | Register address |
| bus_read_o | output | 1 | Read request |
| bus_write_o | output | 1 | Write request |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, valid when read is accepted |
| bus_wait_i | input | 1 | Slave stall; a request completes when low |

## Verification
Two events can land in the same cycle: the `done_o` pulse that closes one run and the start pulse that opens the next. The bench raises `start_i` in exactly the cycle it sees `done_o`. It then judges the new run from its first transfer, and checks that `err_o` and `tap1_o` clear after the timeout run is followed this way. The other coincidence is the poll limit being reached in the same cycle as a read is accepted under random stalls. There, the timeout must produce `done_o` and `err_o` together one cycle later, with no further transfer.

// File: rtl/eyemon_pkg.sv
package eyemon_pkg;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam int NSTEP = 22;
    localparam int SW = $clog2(NSTEP);

    typedef enum logic [2:0] {
        OP_RMW,
        OP_CFG,
        OP_POLL,
        OP_WAIT,
        OP_TAP,
        OP_END
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_READ,
        S_WRITE,
        S_DELAY
    } st_e;

    typedef struct packed {
        logic          en;
        op_e           kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] mask;
        logic [DW-1:0] val;
    } step_t;

    typedef struct packed {
        logic       prod;
        logic       bgcal;
        logic       manual;
        logic       dfe_off;
        logic [2:0] cnt;
        logic [1:0] bw;
    } ctx_t;

    function automatic step_t mk_step(logic en, op_e kind, logic [AW-1:0] addr,
                                      logic [DW-1:0] mask, logic [DW-1:0] val);
        step_t s;
        s.en   = en;
        s.kind = kind;
        s.addr = addr;
        s.mask = mask;
        s.val  = val;
        return s;
    endfunction

    function automatic logic [DW-1:0] field_merge(logic [DW-1:0] old, logic [DW-1:0] mask,
                                                  logic [DW-1:0] val);
        return (old & ~mask) | (val & mask);
    endfunction

endpackage

// File: rtl/eyemon_prog.sv
module eyemon_prog
    import eyemon_pkg::*;
(
    input  logic [SW-1:0] idx_i,
    input  ctx_t          ctx_i,
    output step_t         step_o
);
    logic cal_pause;
    logic dfe_on;

    assign cal_pause = ctx_i.prod & ctx_i.bgcal;
    assign dfe_on    = ~ctx_i.dfe_off;

    always_comb begin
        unique case (idx_i)
            SW'(0):  step_o = mk_step(cal_pause, OP_RMW, 11'h542, 8'h01, 8'h00);
            SW'(1):  step_o = mk_step(cal_pause, OP_POLL, 11'h481, 8'h04, 8'h00);
            SW'(2):  step_o = mk_step(1'b1, OP_CFG, 11'h161, 8'h60, 8'h00);
            SW'(3):  step_o = mk_step(ctx_i.manual, OP_RMW, 11'h148, 8'h01, 8'h01);
            SW'(4):  step_o = mk_step(1'b1, OP_RMW, 11'h169, 8'h40, 8'h40);
            SW'(5):  step_o = mk_step(1'b1, OP_RMW, 11'h168, 8'h01, 8'h01);
            SW'(6):  step_o = mk_step(1'b1, OP_RMW, 11'h169, 8'h04, {5'd0, dfe_on, 2'd0});
            SW'(7):  step_o = mk_step(dfe_on, OP_RMW, 11'h149, 8'h3F, 8'h07);
            SW'(8):  step_o = mk_step(dfe_on, OP_WAIT, 11'h000, 8'h00, 8'h00);
            SW'(9):  step_o = mk_step(dfe_on, OP_TAP, 11'h17F, 8'h40, 8'h00);
            SW'(10): step_o = mk_step(1'b1, OP_RMW, 11'h169, 8'h03, {6'd0, ctx_i.cnt[2:1]});
            SW'(11): step_o = mk_step(1'b1, OP_RMW, 11'h168, 8'h20, {2'd0, ctx_i.cnt[0], 5'd0});
            SW'(12): step_o = mk_step(1'b1, OP_RMW, 11'h158, 8'h20, 8'h20);
            SW'(13): step_o = mk_step(1'b1, OP_RMW, 11'h12D, 8'h10, 8'h00);
            SW'(14): step_o = mk_step(1'b1, OP_RMW, 11'h145, 8'h80, {ctx_i.bw[1], 7'd0});
            SW'(15): step_o = mk_step(1'b1, OP_RMW, 11'h144, 8'h80, {ctx_i.bw[0], 7'd0});
            SW'(16): step_o = mk_step(1'b1, OP_RMW, 11'h144, 8'h70, 8'h00);
            SW'(17): step_o = mk_step(1'b1, OP_RMW, 11'h140, 8'h38, 8'h00);
            SW'(18): step_o = mk_step(1'b1, OP_RMW, 11'h13C, 8'h01, 8'h00);
            SW'(19): step_o = mk_step(1'b1, OP_RMW, 11'h13C, 8'h01, 8'h01);
            SW'(20): step_o = mk_step(1'b1, OP_RMW, 11'h171, 8'h1E, 8'h16);
            default: step_o = mk_step(1'b1, OP_END, 11'h000, 8'h00, 8'h00);
        endcase
    end
endmodule

// File: rtl/eyemon_delay.sv
module eyemon_delay #(
    parameter int LEN = 3125
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic expired_o
);
    localparam int CW = $clog2(LEN + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } dly_t;

    dly_t d_d, d_q;

    assign expired_o = d_q.busy && (d_q.cnt == '0);

    always_comb begin
        d_d = d_q;
        if (start_i) begin
            d_d.busy = 1'b1;
            d_d.cnt  = CW'(LEN - 1);
        end else if (d_q.busy) begin
            if (d_q.cnt == '0) begin
                d_d.busy = 1'b0;
            end else begin
                d_d.cnt = d_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end
endmodule

// File: rtl/eyemon_enable_seq.sv
module eyemon_enable_seq
    import eyemon_pkg::*;
#(
    parameter int CLK_MHZ  = 125,
    parameter int WAIT_US  = 25,
    parameter int POLL_MAX = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          prod_i,
    input  logic          bgcal_i,
    input  logic [2:0]    cnt_code_i,
    input  logic [1:0]    bw_code_i,
    output logic          done_o,
    output logic          err_o,
    output logic          tap1_o,
    output logic [AW-1:0] bus_addr_o,
    output logic          bus_read_o,
    output logic          bus_write_o,
    output logic [DW-1:0] bus_wdata_o,
    input  logic [DW-1:0] bus_rdata_i,
    input  logic          bus_wait_i
);
    localparam int DLY_CYC = CLK_MHZ * WAIT_US;
    localparam int PCW     = $clog2(POLL_MAX + 1);

    typedef struct packed {
        st_e           st;
        logic [SW-1:0] step;
        ctx_t          ctx;
        logic [PCW-1:0] poll;
        logic          rd;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          done;
        logic          err;
        logic          tap;
    } seq_t;

    seq_t  r_d, r_q;
    step_t cur;
    logic  dly_start;
    logic  dly_expired;

    eyemon_prog u_prog (
        .idx_i  (r_q.step),
        .ctx_i  (r_q.ctx),
        .step_o (cur)
    );

    eyemon_delay #(.LEN(DLY_CYC)) u_delay (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (dly_start),
        .expired_o (dly_expired)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        dly_start = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    r_d.ctx.prod    = prod_i;
                    r_d.ctx.bgcal   = bgcal_i;
                    r_d.ctx.manual  = 1'b0;
                    r_d.ctx.dfe_off = 1'b0;
                    r_d.ctx.cnt     = cnt_code_i;
                    r_d.ctx.bw      = bw_code_i;
                    r_d.step        = '0;
                    r_d.err         = 1'b0;
                    r_d.tap         = 1'b0;
                    r_d.st          = S_FETCH;
                end
            end
            S_FETCH: begin
                if (cur.kind == OP_END) begin
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end else if (!cur.en) begin
                    r_d.step = r_q.step + SW'(1);
                end else if (cur.kind == OP_WAIT) begin
                    dly_start = 1'b1;
                    r_d.st    = S_DELAY;
                end else begin
                    r_d.rd   = 1'b1;
                    r_d.addr = cur.addr;
                    r_d.poll = '0;
                    r_d.st   = S_READ;
                end
            end
            S_READ: begin
                if (!bus_wait_i) begin
                    unique case (cur.kind)
                        OP_RMW: begin
                            r_d.rd    = 1'b0;
                            r_d.wr    = 1'b1;
                            r_d.wdata = field_merge(bus_rdata_i, cur.mask, cur.val);
                            r_d.st    = S_WRITE;
                        end
                        OP_CFG: begin
                            r_d.rd          = 1'b0;
                            r_d.ctx.manual  = bus_rdata_i[5];
                            r_d.ctx.dfe_off = bus_rdata_i[6];
                            r_d.step        = r_q.step + SW'(1);
                            r_d.st          = S_FETCH;
                        end
                        OP_TAP: begin
                            r_d.rd   = 1'b0;
                            r_d.tap  = bus_rdata_i[6];
                            r_d.step = r_q.step + SW'(1);
                            r_d.st   = S_FETCH;
                        end
                        OP_POLL: begin
                            if ((bus_rdata_i & cur.mask) == '0) begin
                                r_d.rd   = 1'b0;
                                r_d.step = r_q.step + SW'(1);
                                r_d.st   = S_FETCH;
                            end else if (r_q.poll == PCW'(POLL_MAX - 1)) begin
                                r_d.rd   = 1'b0;
                                r_d.err  = 1'b1;
                                r_d.done = 1'b1;
                                r_d.st   = S_IDLE;
                            end else begin
                                r_d.poll = r_q.poll + PCW'(1);
                            end
                        end
                        default: begin
                            r_d.rd = 1'b0;
                            r_d.st = S_IDLE;
                        end
                    endcase
                end
            end
            S_WRITE: begin
                if (!bus_wait_i) begin
                    r_d.wr   = 1'b0;
                    r_d.step = r_q.step + SW'(1);
                    r_d.st   = S_FETCH;
                end
            end
            S_DELAY: begin
                if (dly_expired) begin
                    r_d.step = r_q.step + SW'(1);
                    r_d.st   = S_FETCH;
                end
            end
            default: begin
                r_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o      = r_q.done;
    assign err_o       = r_q.err;
    assign tap1_o      = r_q.tap;
    assign bus_addr_o  = r_q.addr;
    assign bus_read_o  = r_q.rd;
    assign bus_write_o = r_q.wr;
    assign bus_wdata_o = r_q.wdata;
endmodule

// File: rtl/eyemon_enable_seq_chk.sv
module eyemon_enable_seq_chk #(
    parameter int WAIT_CYC = 3125
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        rd,
    input logic        wr,
    input logic [10:0] addr,
    input logic [7:0]  wdata,
    input logic        waitreq,
    input logic        done,
    input logic        err
);
    int since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= 0;
        end else if (wr && !waitreq && addr == 11'h149) begin
            since_q <= 0;
        end else if (since_q < WAIT_CYC) begin
            since_q <= since_q + 1;
        end
    end

    a_r2_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr));

    a_r2_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && waitreq) |=> (rd && $stable(addr)));

    a_r2_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && waitreq) |=> (wr && $stable(addr) && $stable(wdata)));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!rd && !wr));

    a_r5_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    a_r5_err_until_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(start));

    a_r7_wait_min: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 11'h17F && !$past(rd)) |-> (since_q >= WAIT_CYC));
endmodule

bind eyemon_enable_seq eyemon_enable_seq_chk #(.WAIT_CYC(CLK_MHZ * WAIT_US)) u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .start   (start_i),
    .rd      (bus_read_o),
    .wr      (bus_write_o),
    .addr    (bus_addr_o),
    .wdata   (bus_wdata_o),
    .waitreq (bus_wait_i),
    .done    (done_o),
    .err     (err_o)
);

// File: tb/eyemon_enable_seq_test.sv
module eyemon_enable_seq_test;
    localparam int POLL_MAX = 8;
    localparam int DLY      = 125 * 25;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        prod_i = 1'b0;
    logic        bgcal_i = 1'b0;
    logic [2:0]  cnt_code_i = '0;
    logic [1:0]  bw_code_i = '0;
    logic        done_o, err_o, tap1_o;
    logic [10:0] bus_addr_o;
    logic        bus_read_o, bus_write_o;
    logic [7:0]  bus_wdata_o;
    logic [7:0]  bus_rdata_i = '0;
    logic        bus_wait_i = 1'b0;

    always #4 clk = ~clk;

    eyemon_enable_seq uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start_i),
        .prod_i      (prod_i),
        .bgcal_i     (bgcal_i),
        .cnt_code_i  (cnt_code_i),
        .bw_code_i   (bw_code_i),
        .done_o      (done_o),
        .err_o       (err_o),
        .tap1_o      (tap1_o),
        .bus_addr_o  (bus_addr_o),
        .bus_read_o  (bus_read_o),
        .bus_write_o (bus_write_o),
        .bus_wdata_o (bus_wdata_o),
        .bus_rdata_i (bus_rdata_i),
        .bus_wait_i  (bus_wait_i)
    );

    typedef struct {
        bit wr;
        int addr;
        int data;
    } xfer_t;

    xfer_t      exq[$];
    logic [7:0] mem[0:2047];
    logic [7:0] shadow[0:2047];
    int vectors = 0, fails = 0, cyc = 0;
    int exp_done_cyc = -1;
    bit exp_err = 0, exp_tap = 0, exp_timeout = 0, levels_on = 0;
    bit wmode = 0;
    int busy_left = 0, poll_reads = 0;
    int w149_cyc = -1;
    bit tap_seen = 0;
    bit p_wait = 0, p_rd = 0, p_wr = 0;
    int p_addr = 0, p_wdata = 0;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic q_rd(int a);
        exq.push_back('{0, a, 0});
    endtask

    task automatic q_rmw(int a, int m, int v);
        int nv;
        q_rd(a);
        nv = (int'(shadow[a]) & ~m & 255) | (v & m);
        shadow[a] = nv[7:0];
        exq.push_back('{1, a, nv});
    endtask

    task automatic build(bit prod, bit bg, int code, int bw, int busy);
        bit man, doff;
        exq.delete();
        for (int a = 0; a < 2048; a++) shadow[a] = mem[a];
        exp_err = 0; exp_tap = 0; exp_timeout = 0;
        if (prod && bg) begin
            q_rmw('h542, 'h01, 0);
            if (busy >= POLL_MAX) begin
                for (int i = 0; i < POLL_MAX; i++) q_rd('h481);
                exp_err = 1; exp_timeout = 1;
                return;
            end
            for (int i = 0; i <= busy; i++) q_rd('h481);
        end
        q_rd('h161);
        man  = shadow['h161][5];
        doff = shadow['h161][6];
        if (man) q_rmw('h148, 'h01, 1);
        q_rmw('h169, 'h40, 'h40);
        q_rmw('h168, 'h01, 1);
        q_rmw('h169, 'h04, doff ? 0 : 4);
        if (!doff) begin
            q_rmw('h149, 'h3F, 'h07);
            q_rd('h17F);
            exp_tap = shadow['h17F][6];
        end
        q_rmw('h169, 'h03, code >> 1);
        q_rmw('h168, 'h20, (code & 1) << 5);
        q_rmw('h158, 'h20, 'h20);
        q_rmw('h12D, 'h10, 0);
        q_rmw('h145, 'h80, ((bw >> 1) & 1) << 7);
        q_rmw('h144, 'h80, (bw & 1) << 7);
        q_rmw('h144, 'h70, 0);
        q_rmw('h140, 'h38, 0);
        q_rmw('h13C, 'h01, 0);
        q_rmw('h13C, 'h01, 1);
        q_rmw('h171, 'h1E, 'h16);
    endtask

    // One clock of bench activity, all at the falling edge.
    task automatic tick();
        bit exp_d;
        xfer_t e;
        @(negedge clk);
        cyc++;
        if (cyc > WD_LIMIT) begin
            fails++;
            $display("FAIL watchdog: run did not end, cycle %0d", cyc);
            summary();
            $finish;
        end
        exp_d = (cyc == exp_done_cyc);
        chk(done_o == exp_d, "R11 done timing", int'(done_o), int'(exp_d));
        if (done_o && exp_d) begin
            chk(err_o == exp_err, "R5 error flag at done", int'(err_o), int'(exp_err));
            chk(tap1_o == exp_tap, "R7 tap sign at done", int'(tap1_o), int'(exp_tap));
            levels_on = 1;
        end else if (levels_on) begin
            chk(err_o == exp_err, "R11 error held", int'(err_o), int'(exp_err));
            chk(tap1_o == exp_tap, "R11 tap held", int'(tap1_o), int'(exp_tap));
        end
        chk(!(bus_read_o && bus_write_o), "R2 single access", int'({bus_read_o, bus_write_o}), 0);
        if (p_wait && (p_rd || p_wr)) begin
            chk(bus_read_o == p_rd && bus_write_o == p_wr && int'(bus_addr_o) == p_addr
                && (!p_wr || int'(bus_wdata_o) == p_wdata),
                "R2 request held", int'(bus_addr_o), p_addr);
        end
        if (bus_read_o && bus_addr_o == 11'h17F && !tap_seen) begin
            tap_seen = 1;
            chk(w149_cyc >= 0 && cyc - w149_cyc >= DLY && cyc - w149_cyc <= DLY + 4,
                "R7 settle wait", cyc - w149_cyc, DLY);
        end
        // responder
        bus_wait_i = wmode ? ($urandom % 3 == 0) : 1'b0;
        if (bus_addr_o == 11'h481)
            bus_rdata_i = (mem['h481] & 8'hFB) | (busy_left > 0 ? 8'h04 : 8'h00);
        else
            bus_rdata_i = mem[bus_addr_o];
        if ((bus_read_o || bus_write_o) && !bus_wait_i) begin
            if (exq.size() == 0) begin
                chk(0, "R1 unexpected transfer", int'(bus_addr_o), 0);
            end else begin
                e = exq.pop_front();
                chk(e.wr == bus_write_o && e.addr == int'(bus_addr_o), "R10 transfer order",
                    int'({bus_write_o, bus_addr_o}), int'({e.wr, e.addr[10:0]}));
                if (bus_write_o)
                    chk(e.data == int'(bus_wdata_o), "R3 merged write data",
                        int'(bus_wdata_o), e.data);
                if (exq.size() == 0) exp_done_cyc = cyc + (exp_timeout ? 1 : 2);
            end
            if (bus_write_o) begin
                mem[bus_addr_o] = bus_wdata_o;
                if (bus_addr_o == 11'h149) w149_cyc = cyc;
            end
            if (bus_read_o && bus_addr_o == 11'h481) begin
                poll_reads++;
                if (busy_left > 0) busy_left--;
            end
        end
        p_wait = bus_wait_i; p_rd = bus_read_o; p_wr = bus_write_o;
        p_addr = int'(bus_addr_o); p_wdata = int'(bus_wdata_o);
    endtask

    // Starts a run at the current falling edge.
    task automatic run_begin(bit prod, bit bg, int code, int bw, bit man, bit doff,
                             int busy, bit wm);
        mem['h161][5] = man;
        mem['h161][6] = doff;
        build(prod, bg, code, bw, busy);
        busy_left = busy; poll_reads = 0; w149_cyc = -1; tap_seen = 0;
        exp_done_cyc = -1; levels_on = 0; wmode = wm;
        prod_i = prod; bgcal_i = bg; cnt_code_i = 3'(code); bw_code_i = 2'(bw);
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
    endtask

    // Runs until done; a second start with other inputs can be injected.
    task automatic run_wait(bit disturb, int code, int bw, bit bg, int busy);
        int n = 0;
        bit bad_mem = 0;
        while (!(done_o && cyc == exp_done_cyc)) begin
            if (disturb && n == 10) begin
                start_i = 1'b1; cnt_code_i = ~cnt_code_i; bw_code_i = ~bw_code_i;
                prod_i = ~prod_i;
            end
            if (disturb && n == 11) start_i = 1'b0;
            tick();
            n++;
            if (n > 20000) begin
                chk(0, "R11 done never seen", n, 0);
                return;
            end
        end
        if (disturb) chk(exq.size() == 0, "R1 restart ignored", exq.size(), 0);
        for (int a = 0; a < 2048; a++) if (mem[a] !== shadow[a]) bad_mem = 1;
        chk(!bad_mem, "R3 register image preserved", int'(bad_mem), 0);
        if (!exp_timeout) begin
            chk(mem['h169][1:0] == 2'(code >> 1), "R8 count code high bits",
                int'(mem['h169][1:0]), code >> 1);
            chk(mem['h168][5] == code[0], "R8 count code low bit",
                int'(mem['h168][5]), code & 1);
            chk(mem['h145][7] == bw[1] && mem['h144][7] == bw[0], "R9 bandwidth bits",
                int'({mem['h145][7], mem['h144][7]}), bw);
            chk(mem['h171][4:1] == 4'hB, "R10 final mux field", int'(mem['h171][4:1]), 'hB);
        end
        chk(poll_reads == (bg && prod_i ? (busy >= POLL_MAX ? POLL_MAX : busy + 1) : 0),
            "R4 status poll count", poll_reads, busy);
    endtask

    initial begin
        for (int a = 0; a < 2048; a++) mem[a] = 8'((a * 73 + 29) ^ (a >> 3));
        mem['h17F][6] = 1'b1;
        mem['h148][0] = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(!done_o && !err_o && !tap1_o && !bus_read_o && !bus_write_o, "R12 reset state",
            int'({done_o, err_o, tap1_o, bus_read_o, bus_write_o}), 0);

        // full program, manual adaptation, equalizer on, stalls
        run_begin(1, 1, 5, 2, 1, 0, 3, 1);
        run_wait(0, 5, 2, 1, 3);
        chk(mem['h148][0] == 1'b1, "R6 adaptation release", int'(mem['h148][0]), 1);
        repeat (4) tick();

        // equalizer off, no calibration pause, disturbed by a second start
        mem['h169][2] = 1'b1;
        run_begin(1, 0, 6, 1, 0, 1, 0, 0);
        run_wait(1, 6, 1, 0, 0);
        chk(mem['h169][2] == 1'b0, "R7 speculation cleared", int'(mem['h169][2]), 0);
        repeat (4) tick();

        // non-production, calibration flag alone skips the pause
        mem['h17F][6] = 1'b0;
        run_begin(0, 1, 0, 3, 0, 0, 5, 1);
        run_wait(0, 0, 3, 1, 5);
        repeat (3) tick();

        // poll never clears: timeout
        mem['h17F][6] = 1'b1;
        run_begin(1, 1, 4, 0, 1, 0, 40, 1);
        run_wait(0, 4, 0, 1, 40);
        // start in the same cycle as done
        run_begin(1, 1, 3, 0, 0, 0, 0, 1);
        run_wait(0, 3, 0, 1, 0);
        run_begin(0, 0, 1, 2, 1, 0, 0, 0);
        run_wait(0, 1, 2, 0, 0);
        repeat (6) tick();

        summary();
        $finish;
    end
endmodule